// File: doc/BRIEF.md
# Serial Port Status Flags with Read-Then-Write-Zero Clearing

This block keeps the sticky error and status bits of a serial port and enforces how they may change. The receiver reports each finished frame with a one-cycle strobe, qualified by a parity-mismatch level and a stop-bit (framing) error level. The transmit side, when in smart card mode, strobes the sampled level of the returned error line. From these events the block sets a receive-data-full bit, a parity error bit, a framing error bit and a returned-error bit. It also produces a one-cycle write strobe for the receive data register, and the gates that allow reception and transmission.

Software sees the four bits through a small read/write port. A bit goes back to 0 only when software writes 0 to it after a read that returned it as 1. A parity error stores the byte but leaves the data-full bit alone. It then holds off further reception, and in synchronous mode it also holds off transmission, until software clears it. Reset and standby both wipe every bit.

Top module: `serial_flag_ctrl`

## Requirements
- R1: A high `rst` or `standby` at a clock edge clears all four flags, all read markers, `reg_rdata` and `rdr_we` by the next cycle.
- R2: An accepted frame with `par_bad` high sets the parity flag (bit 1) and pulses `rdr_we` for one cycle after the edge. The data-full flag (bit 0) does not set.
- R3: An accepted frame with no counted error sets the data-full flag (bit 0) and pulses `rdr_we` for one cycle after the edge.
- R4: A frame is accepted only when `rx_en` is 1 and the parity flag is 0, and `rx_allow` shows exactly this condition. A frame that arrives while the parity flag is 1 changes no flag and gives no `rdr_we`. `tx_allow` is `tx_en` gated by the parity flag only when `sync_mode` is 1.
- R5: Dropping `rx_en` leaves the parity flag unchanged. Dropping `tx_en` leaves the returned-error flag unchanged.
- R6: The returned-error flag (bit 3) sets when `err_stb` is high, `err_line` is 0 and `sc_mode` is 1. It does not set if `sc_mode` is 0 or the line is high.
- R7: The framing flag (bit 2) sets on an accepted frame with `frm_bad` only while `sc_mode` is 0. In smart card mode `frm_bad` is ignored, and the frame counts as good for the data-full flag.
- R8: A flag clears on a `reg_wr` whose data bit is 0 only if an earlier `reg_rd` saw that flag as 1. A write of 0 with no such read, or a write of 1, leaves the flag as it is.
- R9: A clearing write consumes that flag's read marker, so a later write of 0 needs a fresh read that returns 1.
- R10: If a flag's set event and a qualifying clearing write occur in the same cycle, the flag stays 1 and its read marker is kept.
- R11: `reg_rd` loads `reg_rdata` at the next edge with the flags as they were in that cycle: bit 0 data-full, bit 1 parity, bit 2 framing, bit 3 returned-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Standby entry, same effect as reset |
| sc_mode | input | 1 | Smart card mode select |
| sync_mode | input | 1 | Synchronous mode select |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| frame_vld | input | 1 | Received frame done strobe |
| par_bad | input | 1 | Parity mismatch qualifier for frame_vld |
| frm_bad | input | 1 | Stop-bit error qualifier for frame_vld |
| err_stb | input | 1 | Error line sample strobe |
| err_line | input | 1 | Sampled returned error line level |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 4 | Status write data |
| reg_rdata | output | 4 | Registered status read data |
| flags | output | 4 | Current flag bits |
| rdrf | output | 1 | Receive data full flag |
| rdr_we | output | 1 | Receive data register write strobe |
| rx_allow | output | 1 | Reception permitted |
| tx_allow | output | 1 | Transmission permitted |

## Verification
On every cycle the assertions check the following: a read marker is only ever held under a set flag, a set event always beats a clearing write, a clearing write consumes its marker, and a write of 0 without a marker leaves the flag alone. They also check that the receive gate is low under a parity error, that a new parity error comes with a data write but no data-full rise, and that framing and returned-error bits rise only in the permitted modes. Only the bench's scenarios can show the full read-then-write sequence, the register bit layout, that a blocked frame really leaves every flag alone, and that the enables and standby act as stated. Its model, running across long mixed random traffic, shows this as well.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int NFLAG   = 4;
  localparam int F_RDRF  = 0;
  localparam int F_PAR   = 1;
  localparam int F_FRM   = 2;
  localparam int F_RET   = 3;
endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell (
  input  logic clk,
  input  logic clr_all,
  input  logic set_ev,
  input  logic rd_stb,
  input  logic wr_zero,
  output logic flag
);
  logic mark;
  logic take_clear;

  assign take_clear = wr_zero & mark & ~set_ev;

  always_ff @(posedge clk) begin
    if (clr_all) begin
      flag <= 1'b0;
      mark <= 1'b0;
    end else begin
      flag <= set_ev | (flag & ~take_clear);
      if (take_clear)
        mark <= 1'b0;
      else if (rd_stb && flag)
        mark <= 1'b1;
    end
  end

  a_r8_mark_needs_flag: assert property (@(posedge clk) disable iff (clr_all)
    mark |-> flag);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (clr_all)
    set_ev |=> flag);
  a_r9_mark_consumed: assert property (@(posedge clk) disable iff (clr_all)
    (wr_zero && mark && !set_ev) |=> (!flag && !mark));
  a_r8_no_blind_clear: assert property (@(posedge clk) disable iff (clr_all)
    (wr_zero && !mark && flag) |=> flag);
endmodule

// File: rtl/ssf_event_gate.sv
module ssf_event_gate
  import ssf_pkg::*;
(
  input  logic             sc_mode,
  input  logic             sync_mode,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             frame_vld,
  input  logic             par_bad,
  input  logic             frm_bad,
  input  logic             err_stb,
  input  logic             err_line,
  input  logic             par_q,
  output logic [NFLAG-1:0] set_vec,
  output logic             accept,
  output logic             rx_ok,
  output logic             tx_ok
);
  logic frm_count;

  assign rx_ok     = rx_en & ~par_q;
  assign tx_ok     = tx_en & ~(sync_mode & par_q);
  assign accept    = frame_vld & rx_ok;
  assign frm_count = frm_bad & ~sc_mode;

  always_comb begin
    set_vec         = '0;
    set_vec[F_RDRF] = accept & ~par_bad & ~frm_count;
    set_vec[F_PAR]  = accept & par_bad;
    set_vec[F_FRM]  = accept & frm_count;
    set_vec[F_RET]  = sc_mode & err_stb & ~err_line;
  end
endmodule

// File: rtl/serial_flag_ctrl.sv
module serial_flag_ctrl
  import ssf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             standby,
  input  logic             sc_mode,
  input  logic             sync_mode,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             frame_vld,
  input  logic             par_bad,
  input  logic             frm_bad,
  input  logic             err_stb,
  input  logic             err_line,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [NFLAG-1:0] reg_wdata,
  output logic [NFLAG-1:0] reg_rdata,
  output logic [NFLAG-1:0] flags,
  output logic             rdrf,
  output logic             rdr_we,
  output logic             rx_allow,
  output logic             tx_allow
);
  logic             clr_all;
  logic [NFLAG-1:0] set_vec;
  logic             accept;

  assign clr_all = rst | standby;

  ssf_event_gate u_gate (
    .sc_mode   (sc_mode),
    .sync_mode (sync_mode),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .frame_vld (frame_vld),
    .par_bad   (par_bad),
    .frm_bad   (frm_bad),
    .err_stb   (err_stb),
    .err_line  (err_line),
    .par_q     (flags[F_PAR]),
    .set_vec   (set_vec),
    .accept    (accept),
    .rx_ok     (rx_allow),
    .tx_ok     (tx_allow)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ssf_flag_cell u_cell (
      .clk     (clk),
      .clr_all (clr_all),
      .set_ev  (set_vec[i]),
      .rd_stb  (reg_rd),
      .wr_zero (reg_wr & ~reg_wdata[i]),
      .flag    (flags[i])
    );
  end

  assign rdrf = flags[F_RDRF];

  always_ff @(posedge clk) begin
    if (clr_all) begin
      rdr_we    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      rdr_we <= accept;
      if (reg_rd)
        reg_rdata <= flags;
    end
  end

  a_r1_clear_all: assert property (@(posedge clk)
    clr_all |=> (flags == '0 && !rdr_we && reg_rdata == '0));
  a_r4_rx_blocked: assert property (@(posedge clk) disable iff (clr_all)
    flags[F_PAR] |-> !rx_allow);
  a_r2_par_stores_data: assert property (@(posedge clk) disable iff (clr_all)
    $rose(flags[F_PAR]) |-> (rdr_we && !$rose(flags[F_RDRF])));
  a_r7_no_frm_in_sc: assert property (@(posedge clk) disable iff (clr_all)
    $rose(flags[F_FRM]) |-> !$past(sc_mode));
  a_r6_ret_on_low_line: assert property (@(posedge clk) disable iff (clr_all)
    $rose(flags[F_RET]) |-> ($past(sc_mode) && !$past(err_line)));
endmodule

// File: tb/serial_flag_ctrl_test.sv
module serial_flag_ctrl_test;
  logic clk = 1'b0;
  logic rst, standby, sc_mode, sync_mode, rx_en, tx_en;
  logic frame_vld, par_bad, frm_bad, err_stb, err_line, reg_rd, reg_wr;
  logic [3:0] reg_wdata, reg_rdata, flags;
  logic rdrf, rdr_we, rx_allow, tx_allow;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_flag, m_mark, m_rdata;
  logic m_we;

  always #10 clk = ~clk;

  serial_flag_ctrl uut (
    .clk(clk), .rst(rst), .standby(standby), .sc_mode(sc_mode),
    .sync_mode(sync_mode), .rx_en(rx_en), .tx_en(tx_en),
    .frame_vld(frame_vld), .par_bad(par_bad), .frm_bad(frm_bad),
    .err_stb(err_stb), .err_line(err_line), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flags(flags), .rdrf(rdrf), .rdr_we(rdr_we),
    .rx_allow(rx_allow), .tx_allow(tx_allow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] set_events(input logic acc);
    logic [3:0] s;
    logic fc;
    fc   = frm_bad & ~sc_mode;
    s[0] = acc & ~par_bad & ~fc;
    s[1] = acc & par_bad;
    s[2] = acc & fc;
    s[3] = sc_mode & err_stb & ~err_line;
    return s;
  endfunction

  // one clock: update model from current inputs, then compare after the edge
  task automatic step(input string req);
    logic acc;
    logic [3:0] s;
    if (rst || standby) begin
      m_flag = '0; m_mark = '0; m_rdata = '0; m_we = 1'b0;
    end else begin
      acc = frame_vld & rx_en & ~m_flag[1];
      s = set_events(acc);
      if (reg_rd) m_rdata = m_flag;
      for (int i = 0; i < 4; i++) begin
        logic tk;
        tk = reg_wr & ~reg_wdata[i] & m_mark[i] & ~s[i];
        if (tk) m_mark[i] = 1'b0;
        else if (reg_rd && m_flag[i]) m_mark[i] = 1'b1;
        m_flag[i] = s[i] | (m_flag[i] & ~tk);
      end
      m_we = acc;
    end
    @(posedge clk);
    @(negedge clk);
    frame_vld = 0; err_stb = 0; reg_rd = 0; reg_wr = 0; standby = 0;
    check(req, {28'd0, flags}, {28'd0, m_flag});
    check(req, {31'd0, rdr_we}, {31'd0, m_we});
    check(req, {28'd0, reg_rdata}, {28'd0, m_rdata});
    check(req, {31'd0, rdrf}, {31'd0, m_flag[0]});
    check(req, {31'd0, rx_allow}, {31'd0, rx_en & ~m_flag[1]});
    check(req, {31'd0, tx_allow}, {31'd0, tx_en & ~(sync_mode & m_flag[1])});
  endtask

  task automatic frame(input logic pb, input logic fb, input string req);
    frame_vld = 1; par_bad = pb; frm_bad = fb;
    step(req);
    par_bad = 0; frm_bad = 0;
  endtask

  task automatic rd(input string req);
    reg_rd = 1; step(req);
  endtask

  task automatic wr(input logic [3:0] d, input string req);
    reg_wr = 1; reg_wdata = d; step(req);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; standby = 0; sc_mode = 0; sync_mode = 0; rx_en = 1; tx_en = 1;
    frame_vld = 0; par_bad = 0; frm_bad = 0; err_stb = 0; err_line = 1;
    reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    m_flag = '0; m_mark = '0; m_rdata = '0; m_we = 0;
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    check("R1", {28'd0, flags}, 0);
    check("R1", {31'd0, rdr_we}, 0);

    // R3 good frame
    frame(0, 0, "R3");
    check("R3", {28'd0, flags}, 32'h1);
    check("R3", {31'd0, rdr_we}, 1);
    step("R3");
    check("R3", {31'd0, rdr_we}, 0);

    // R2 parity error after standby wipe
    standby = 1; step("R1");
    check("R1", {28'd0, flags}, 0);
    frame(1, 0, "R2");
    check("R2", {28'd0, flags}, 32'h2);
    check("R2", {31'd0, rdr_we}, 1);

    // R4 blocking
    frame(0, 0, "R4");
    check("R4", {28'd0, flags}, 32'h2);
    check("R4", {31'd0, rdr_we}, 0);
    check("R4", {31'd0, rx_allow}, 0);
    check("R4", {31'd0, tx_allow}, 1);
    sync_mode = 1; step("R4");
    check("R4", {31'd0, tx_allow}, 0);
    sync_mode = 0;

    // R5 receive enable off keeps parity flag
    rx_en = 0; step("R5"); step("R5");
    check("R5", {31'd0, flags[1]}, 1);
    rx_en = 1;

    // R8 handshake
    wr(4'h0, "R8");
    check("R8", {31'd0, flags[1]}, 1);
    rd("R11");
    check("R11", {28'd0, reg_rdata}, 32'h2);
    wr(4'hF, "R8");
    check("R8", {31'd0, flags[1]}, 1);
    wr(4'h0, "R8");
    check("R8", {31'd0, flags[1]}, 0);

    // R9 marker consumed
    frame(1, 0, "R9");
    check("R9", {31'd0, flags[1]}, 1);
    wr(4'h0, "R9");
    check("R9", {31'd0, flags[1]}, 1);
    rd("R9"); wr(4'h0, "R9");
    check("R9", {31'd0, flags[1]}, 0);

    // R6 returned error line
    err_stb = 1; err_line = 0; step("R6");
    check("R6", {31'd0, flags[3]}, 0);
    sc_mode = 1;
    err_stb = 1; err_line = 1; step("R6");
    check("R6", {31'd0, flags[3]}, 0);
    err_stb = 1; err_line = 0; step("R6");
    check("R6", {31'd0, flags[3]}, 1);
    tx_en = 0; step("R5"); step("R5");
    check("R5", {31'd0, flags[3]}, 1);
    tx_en = 1;

    // R10 set beats clear
    rd("R10");
    reg_wr = 1; reg_wdata = 4'h0; err_stb = 1; err_line = 0; step("R10");
    check("R10", {31'd0, flags[3]}, 1);
    wr(4'h0, "R10");
    check("R10", {31'd0, flags[3]}, 0);

    // R7 framing in and out of smart card mode
    rd("R7"); wr(4'h0, "R7");
    frame(0, 1, "R7");
    check("R7", {31'd0, flags[2]}, 0);
    check("R7", {31'd0, flags[0]}, 1);
    sc_mode = 0;
    frame(0, 1, "R7");
    check("R7", {31'd0, flags[2]}, 1);

    // random traffic against the model
    for (int n = 0; n < 6000; n++) begin
      standby   = ($urandom % 300) == 0;
      sc_mode   = ($urandom % 16) == 0 ? ~sc_mode : sc_mode;
      sync_mode = ($urandom % 16) == 0 ? ~sync_mode : sync_mode;
      rx_en     = ($urandom % 10) != 0;
      tx_en     = ($urandom % 10) != 0;
      frame_vld = ($urandom % 4) == 0;
      par_bad   = ($urandom % 5) == 0;
      frm_bad   = ($urandom % 5) == 0;
      err_stb   = ($urandom % 6) == 0;
      err_line  = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: reg_rd = 1;
        1: begin reg_wr = 1; reg_wdata = 4'($urandom); end
        default: ;
      endcase
      step("R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule